// File: doc/BRIEF.md
# Decimal Index Register Store Unit

This block is the execute stage of the store-index-register instruction (opcode 68) on a digit-serial decimal machine. Upstream logic resolves indirection and addressing and hands over four things: a two-digit BCD destination length with a literal flag, a store variant digit, the final address-controller type, and a one-cycle start pulse. The unit then checks the request against the fault rules. If it passes, the unit streams the destination field one digit per cycle to a memory write port, starting with the most significant digit.

Each index register holds a sign digit, a base-indicant digit and `OFS_DIGITS` offset digits. The unit reads the registers through a combinational read port. A single-register store takes registers 1 to 7. A multi-register store takes the four mobile registers 4, 5, 6 and 7, in that order. When a store finishes, the unit pulses `done` together with either a BCD fault code or a new comparison-flag value. The unit has no overflow output, so the overflow flag is never touched.

Top module: `ixreg_store_unit`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `wr_en` and `cmp_we` are all low.
- R2: A literal destination length (`af_lit`=1) ends the store with `fault_code`=8'h21 and no digit written. This check has the highest priority.
- R3: A variant value of 8 to 15 ends the store with `fault_code`=8'h26 and no digit written. Only R2 takes priority over this check.
- R4: `ac_type` encodes 2'b00 as unsigned and 2'b01 as signed. Any other value ends the store with code 8'h03. Variant 0 with a signed controller also ends with 8'h03. Only R2 and R3 take priority over these checks.
- R5: Variant 0 with a destination length other than 00 ends with code 8'h25. This is checked after R4.
- R6: For a single-register store, a destination length of 00 means OFS_DIGITS+2 digits.
- R7: Let D be the data length: the field length minus one for a signed store, or the whole field length otherwise. When D ≥ OFS_DIGITS+1, the data digits are D−OFS_DIGITS−1 zeros, then the base digit, then the offset digits from most to least significant.
- R8: When D ≤ OFS_DIGITS, count the offset digits from the first non-zero digit down to the least significant one. If that count exceeds D, the store ends with code 8'h07 and no write. Otherwise the data digits are the D least significant offset digits.
- R9: A signed single store writes offset 0 as 4'hD if the register's sign digit is 4'hD, and as 4'hC otherwise.
- R10: Variant 0 writes 4·(OFS_DIGITS+2) digits, register 4 first and register 7 last. Each register is written as a zero, then its base digit, then its offset digits.
- R11: A successful single store pulses `cmp_we` with `done` and sets `cmp_code`. The value is 2'b00 (EQUAL) if every offset digit is 0. Otherwise it is 2'b11 (NULL) if every offset digit is 4'hE. Otherwise it is 2'b01 (LOW) for sign 4'hD and 2'b10 (HIGH) for any other sign.
- R12: A variant-0 store or any faulted store leaves `cmp_we` low.
- R13: Write offsets run 0, 1, 2, … on consecutive cycles, beginning two clock edges after the start edge. `done` rises one cycle after the last write. On a fault, `done` rises at the second edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a store, sampled while idle |
| af_len | input | 8 | Destination length, two BCD digits |
| af_lit | input | 1 | Destination length was flagged literal |
| variant | input | 4 | Store variant digit |
| ac_type | input | 2 | Final address controller: 00 unsigned, 01 signed |
| rd_idx | output | 3 | Index register being read |
| rd_reg | input | 4*(OFS_DIGITS+2) | Selected register: sign, base, offset (least significant digit in bits 3:0) |
| wr_en | output | 1 | Destination digit write strobe |
| wr_ofs | output | 8 | Digit offset from the destination start |
| wr_digit | output | 4 | Digit to write |
| busy | output | 1 | Store in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a fault |
| fault_code | output | 8 | BCD fault code, valid with `fault` |
| cmp_we | output | 1 | Comparison-flag update strobe |
| cmp_code | output | 2 | New comparison-flag value |

## Verification
The bench targets the truncation boundary, where the data length is exactly the offset length or one more. A wrong comparison there either drops a significant digit without a fault or drops the base digit. It also covers a signed one-digit field, where only a zero offset may pass, and the stacking of fault conditions, where a wrong priority reports the wrong code. Registers whose offsets are all zero, all E, or led by zeros separate the EQUAL, NULL and sign-based flag results. Multi-register stores show whether register order and the flag hold are kept.

// File: rtl/ixreg_store_unit.sv
module ixreg_store_unit #(
  parameter int OFS_DIGITS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [7:0]                  af_len,
  input  logic                        af_lit,
  input  logic [3:0]                  variant,
  input  logic [1:0]                  ac_type,
  output logic [2:0]                  rd_idx,
  input  logic [4*(OFS_DIGITS+2)-1:0] rd_reg,
  output logic                        wr_en,
  output logic [7:0]                  wr_ofs,
  output logic [3:0]                  wr_digit,
  output logic                        busy,
  output logic                        done,
  output logic                        fault,
  output logic [7:0]                  fault_code,
  output logic                        cmp_we,
  output logic [1:0]                  cmp_code
);
  localparam int REG_LEN   = OFS_DIGITS + 2;
  localparam int MULTI_LEN = 4 * REG_LEN;
  localparam int RW        = 4 * REG_LEN;
  localparam int SW        = $clog2(REG_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WRITE} st_t;
  st_t state;

  logic [3:0]    var_q;
  logic [1:0]    ac_q;
  logic [7:0]    af_q, len_q, cnt, rpos;
  logic          lit_q;
  logic [SW-1:0] sub;
  logic [1:0]    ridx;

  wire       four   = (var_q == 4'd0);
  wire       sn     = (ac_q == 2'b01);
  wire [3:0] r_sign = rd_reg[RW-1 -: 4];
  wire [3:0] r_base = rd_reg[RW-5 -: 4];
  wire [7:0] af_val = 8'(af_len[7:4] * 4'd10) + 8'(af_len[3:0]);
  wire [7:0] dlen   = len_q - 8'(sn);
  wire       last   = (cnt == len_q - 8'd1);

  int   lz;
  logic seen, all_e, bad;
  logic [7:0] code;
  logic [1:0] flag;

  always_comb begin
    lz = 0; seen = 1'b0; all_e = 1'b1;
    for (int i = OFS_DIGITS - 1; i >= 0; i--) begin
      if (!seen && rd_reg[4*i +: 4] == 4'h0) lz++;
      else seen = 1'b1;
      if (rd_reg[4*i +: 4] != 4'hE) all_e = 1'b0;
    end
  end

  always_comb begin
    bad = 1'b1;
    if (lit_q)                                   code = 8'h21;
    else if (var_q > 4'd7)                       code = 8'h26;
    else if (ac_q[1] || (four && sn))            code = 8'h03;
    else if (four && af_q != 8'h00)              code = 8'h25;
    else if (!four && int'(dlen) <= OFS_DIGITS &&
             (OFS_DIGITS - lz) > int'(dlen))      code = 8'h07;
    else begin
      code = 8'h00; bad = 1'b0;
    end
  end

  always_comb begin
    if (lz == OFS_DIGITS)   flag = 2'b00;
    else if (all_e)         flag = 2'b11;
    else if (r_sign == 4'hD) flag = 2'b01;
    else                    flag = 2'b10;
  end

  assign rpos = four ? 8'(REG_LEN - 1) - 8'(sub) : len_q - 8'd1 - cnt;

  always_comb begin
    wr_digit = 4'h0;
    if (!four && sn && cnt == 8'd0) wr_digit = (r_sign == 4'hD) ? 4'hD : 4'hC;
    else if (rpos == 8'(OFS_DIGITS)) wr_digit = r_base;
    else
      for (int i = 0; i < OFS_DIGITS; i++)
        if (rpos == 8'(i)) wr_digit = rd_reg[4*i +: 4];
  end

  assign rd_idx = (state == S_WRITE && four) ? {1'b1, ridx} : var_q[2:0];
  assign wr_en  = (state == S_WRITE);
  assign wr_ofs = cnt;
  assign busy   = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      var_q <= '0; ac_q <= '0; af_q <= '0; len_q <= '0; lit_q <= 1'b0;
      cnt <= '0; sub <= '0; ridx <= '0;
      done <= 1'b0; fault <= 1'b0; fault_code <= '0;
      cmp_we <= 1'b0; cmp_code <= '0;
    end else begin
      done   <= 1'b0;
      fault  <= 1'b0;
      cmp_we <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          var_q <= variant; ac_q <= ac_type; af_q <= af_len; lit_q <= af_lit;
          len_q <= (variant == 4'd0) ? 8'(MULTI_LEN)
                 : (af_val == 8'd0) ? 8'(REG_LEN) : af_val;
          state <= S_CHECK;
        end
        S_CHECK: begin
          cnt <= '0; sub <= '0; ridx <= '0;
          if (bad) begin
            done <= 1'b1; fault <= 1'b1; fault_code <= code;
            state <= S_IDLE;
          end else state <= S_WRITE;
        end
        S_WRITE: begin
          cnt <= cnt + 8'd1;
          if (sub == SW'(REG_LEN - 1)) begin
            sub <= '0; ridx <= ridx + 2'd1;
          end else sub <= sub + SW'(1);
          if (last) begin
            done <= 1'b1; fault_code <= 8'h00;
            cmp_we <= !four; cmp_code <= flag;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R13
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> done && !fault);

  // R8
  fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> !$past(wr_en));

  // R13
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_ofs == 8'($past(wr_ofs) + 8'd1));

  // R9
  sign_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == 8'd0 && sn && !four) |-> (wr_digit == 4'hC || wr_digit == 4'hD));

  // R12
  four_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |-> (done && !fault && var_q != 4'd0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
endmodule

// File: tb/tb_ixreg_store_unit.sv
module tb_ixreg_store_unit;
  localparam int OFS = 6;
  localparam int REG = OFS + 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, af_lit = 1'b0;
  logic [7:0] af_len = '0;
  logic [3:0] variant = '0;
  logic [1:0] ac_type = '0;
  logic [2:0] rd_idx;
  logic [4*REG-1:0] rd_reg;
  logic wr_en, busy, done, fault, cmp_we;
  logic [7:0] wr_ofs, fault_code;
  logic [3:0] wr_digit;
  logic [1:0] cmp_code;

  logic [4*REG-1:0] rf [8];
  assign rd_reg = rf[rd_idx];

  ixreg_store_unit #(.OFS_DIGITS(OFS)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [3:0] exp_d [128];
  int   exp_n, exp_code;
  bit   exp_fault, exp_cwe;
  logic [1:0] exp_cmp;
  string exp_tag;

  function automatic logic [3:0] odig(input logic [4*REG-1:0] r, input int i);
    return r[4*i +: 4];
  endfunction

  task automatic model(input logic [7:0] af, input bit lit, input logic [3:0] v, input logic [1:0] ac);
    int afv, L, D, sig;
    bit sn, nz, ae;
    logic [4*REG-1:0] r;
    afv = af[7:4] * 10 + af[3:0];
    exp_n = 0; exp_fault = 1'b1; exp_cwe = 1'b0; exp_cmp = 2'b00;
    sn = (ac == 2'b01);
    if (lit) begin exp_code = 'h21; exp_tag = "R2"; return; end
    if (v > 7) begin exp_code = 'h26; exp_tag = "R3"; return; end
    if (ac > 1 || (v == 0 && sn)) begin exp_code = 'h03; exp_tag = "R4"; return; end
    if (v == 0 && afv != 0) begin exp_code = 'h25; exp_tag = "R5"; return; end
    exp_code = 0; exp_fault = 1'b0;
    if (v == 0) begin
      exp_tag = "R10";
      for (int k = 4; k < 8; k++) begin
        exp_d[exp_n++] = 4'h0;
        exp_d[exp_n++] = rf[k][4*REG-5 -: 4];
        for (int i = OFS - 1; i >= 0; i--) exp_d[exp_n++] = odig(rf[k], i);
      end
      return;
    end
    r = rf[v[2:0]];
    L = (afv == 0) ? REG : afv;
    exp_tag = sn ? "R9" : (afv == 0 ? "R6" : "R7");
    D = L - (sn ? 1 : 0);
    sig = 0;
    for (int i = 0; i < OFS; i++) if (odig(r, i) != 0) sig = i + 1;
    if (D <= OFS) begin
      exp_tag = "R8";
      if (sig > D) begin exp_fault = 1'b1; exp_code = 'h07; return; end
    end
    if (sn) exp_d[exp_n++] = (r[4*REG-1 -: 4] == 4'hD) ? 4'hD : 4'hC;
    if (D >= OFS + 1) begin
      for (int k = 0; k < D - OFS - 1; k++) exp_d[exp_n++] = 4'h0;
      exp_d[exp_n++] = r[4*REG-5 -: 4];
      for (int i = OFS - 1; i >= 0; i--) exp_d[exp_n++] = odig(r, i);
    end else
      for (int i = D - 1; i >= 0; i--) exp_d[exp_n++] = odig(r, i);
    nz = 1'b0; ae = 1'b1;
    for (int i = 0; i < OFS; i++) begin
      if (odig(r, i) != 0) nz = 1'b1;
      if (odig(r, i) != 4'hE) ae = 1'b0;
    end
    exp_cwe = 1'b1;
    exp_cmp = !nz ? 2'b00 : ae ? 2'b11 : (r[4*REG-1 -: 4] == 4'hD) ? 2'b01 : 2'b10;
  endtask

  task automatic run_op(input logic [7:0] af, input bit lit, input logic [3:0] v, input logic [1:0] ac);
    int cyc, got, dbad;
    bit seen;
    logic [3:0] gd [128];
    model(af, lit, v, ac);
    @(negedge clk);
    af_len = af; af_lit = lit; variant = v; ac_type = ac; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; got = 0; seen = 1'b0; dbad = 0;
    while (cyc < 400 && !seen) begin
      @(negedge clk);
      cyc++;
      if (wr_en) begin
        if (got < 128) gd[got] = wr_digit;
        if (wr_ofs != 8'(got)) dbad++;
        got++;
      end
      if (done) begin
        seen = 1'b1;
        chk(fault == exp_fault, exp_tag, "fault flag", fault, exp_fault);
        if (exp_fault) chk(fault_code == 8'(exp_code), exp_tag, "fault code", fault_code, exp_code);
        chk(cmp_we == exp_cwe, exp_cwe ? "R11" : "R12", "cmp_we", cmp_we, exp_cwe);
        if (exp_cwe) chk(cmp_code == exp_cmp, "R11", "cmp_code", cmp_code, exp_cmp);
      end
    end
    chk(seen, "R13", "done seen", seen, 1);
    chk(cyc == (exp_fault ? 2 : exp_n + 2), "R13", "done cycle", cyc, exp_fault ? 2 : exp_n + 2);
    chk(dbad == 0, "R13", "offset order", dbad, 0);
    chk(got == exp_n, exp_tag, "digit count", got, exp_n);
    if (got == exp_n)
      for (int i = 0; i < exp_n; i++)
        chk(gd[i] == exp_d[i], exp_tag, $sformatf("digit %0d", i), gd[i], exp_d[i]);
  endtask

  function automatic logic [4*REG-1:0] mkreg(input logic [3:0] s, input logic [3:0] b, input int mode, input int lead);
    logic [4*REG-1:0] r;
    r = '0;
    r[4*REG-1 -: 4] = s;
    r[4*REG-5 -: 4] = b;
    for (int i = 0; i < OFS; i++) begin
      case (mode)
        0: r[4*i +: 4] = 4'h0;
        1: r[4*i +: 4] = 4'hE;
        default: r[4*i +: 4] = (i >= OFS - lead) ? 4'h0 : 4'($urandom_range(1, 9));
      endcase
    end
    return r;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rf[0] = '0;
    rf[1] = mkreg(4'hC, 4'h3, 2, 2);
    rf[2] = mkreg(4'hD, 4'h5, 2, 0);
    rf[3] = mkreg(4'hC, 4'h1, 0, 0);
    rf[4] = mkreg(4'hD, 4'h2, 1, 0);
    rf[5] = mkreg(4'hD, 4'h7, 2, 3);
    rf[6] = mkreg(4'hF, 4'h9, 2, 1);
    rf[7] = mkreg(4'hC, 4'h4, 2, 5);
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !fault && !wr_en && !cmp_we, "R1", "reset outputs",
        {busy, done, fault, wr_en, cmp_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(8'h05, 1'b1, 4'd9, 2'b10);
    run_op(8'h05, 1'b0, 4'd9, 2'b10);
    run_op(8'h05, 1'b0, 4'd2, 2'b10);
    run_op(8'h00, 1'b0, 4'd0, 2'b01);
    run_op(8'h05, 1'b0, 4'd0, 2'b00);
    run_op(8'h00, 1'b0, 4'd1, 2'b00);
    run_op(8'h00, 1'b0, 4'd2, 2'b01);
    run_op(8'h12, 1'b0, 4'd5, 2'b00);
    run_op(8'h07, 1'b0, 4'd5, 2'b00);
    run_op(8'h06, 1'b0, 4'd2, 2'b00);
    run_op(8'h04, 1'b0, 4'd1, 2'b00);
    run_op(8'h03, 1'b0, 4'd1, 2'b00);
    run_op(8'h01, 1'b0, 4'd3, 2'b01);
    run_op(8'h01, 1'b0, 4'd7, 2'b01);
    run_op(8'h00, 1'b0, 4'd4, 2'b00);
    run_op(8'h00, 1'b0, 4'd6, 2'b00);
    run_op(8'h00, 1'b0, 4'd0, 2'b00);
    for (int n = 0; n < 250; n++) begin
      logic [7:0] af;
      int k;
      k = $urandom_range(1, 7);
      rf[k] = mkreg($urandom_range(0, 3) == 0 ? 4'hD : 4'hC, 4'($urandom_range(0, 9)),
                    $urandom_range(0, 5), $urandom_range(0, OFS));
      af = {4'($urandom_range(0, 2)), 4'($urandom_range(0, 9))};
      if ($urandom_range(0, 4) == 0) af = 8'h00;
      run_op(af, $urandom_range(0, 30) == 0,
             $urandom_range(0, 20) == 0 ? 4'($urandom_range(8, 15)) : 4'($urandom_range(0, 7)),
             $urandom_range(0, 15) == 0 ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1)));
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule